// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers 8-bit asynchronous serial characters from a single line that idles high. A free-running enable pulse at sixteen times the bit rate drives all of its timing. The line is first brought into the clock domain through a two-stage synchronizer. A position counter then tracks progress through the character in sixteenths of a bit, and the line is sampled once per bit at its middle. A start bit that has gone high again by its own midpoint is treated as noise, and the receiver drops back to idle.

The byte is loaded onto the data output at the middle of the stop bit. The character closes three quarters of the way through the stop bit, which leaves about a quarter bit of slack for a rate mismatch between sender and receiver. At that point a data-available flag inverts, but only if the captured start bit was low and the captured stop bit was high. A consumer detects new data by comparing the flag with its last seen value.

Top module: `uart_oversample_rx`

## Requirements
- R1: A synchronous `clear` sets `rxByte` to 0x00 and `byteToggle` to 0, puts the receiver in idle and presets the synchronizer stages to the line idle level 1.
- R2: A character is a low start bit, eight data bits with the least significant bit first, and a high stop bit, each lasting 16 `tick16` pulses. Every one of the 256 byte values sent this way appears on `rxByte` after the character.
- R3: `byteToggle` inverts exactly once for each character whose start sample is 0 and whose stop sample is 1. `rxByte` and `byteToggle` never change in the same cycle.
- R4: A low pulse on `serialIn` that has ended before the start bit's midpoint (the seventh tick16 after detection) aborts reception. `rxByte` and `byteToggle` are left unchanged.
- R5: A character whose stop bit is sampled low still loads its data into `rxByte`, but `byteToggle` does not invert.
- R6: Position and sample state advance only on `tick16`. With `tick16` held low, activity on `serialIn` changes neither output.
- R7: Characters sent back to back with one stop bit each, at the nominal rate, are all received in order.
- R8: Characters are received correctly when the sender runs about 3 % slow (back to back), or about 3 % fast with one idle bit time between characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clear | input | 1 | Synchronous clear, active high |
| tick16 | input | 1 | Enable pulse at sixteen times the bit rate |
| serialIn | input | 1 | Asynchronous serial line, idle high |
| rxByte | output | 8 | Most recently received byte |
| byteToggle | output | 1 | Inverts when a well-framed character completes |

## Verification
The functions that meet in a single tick are the end of one character, at three quarters of its stop bit, and the start edge of the next character. Trains of back-to-back characters provoke this at the nominal rate and with a slow sender. Every byte must arrive in order and the flag must invert once per character. Two further cases set the start check and the data load against the end-of-character framing test: a glitch shorter than half a bit, and a character with a low stop bit. Both are judged at the outputs: the glitch must leave `rxByte` and `byteToggle` untouched, and the bad-stop character must update the byte without inverting the flag.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // Strobes issued by the control unit to the datapath, each valid for one clock.
  typedef struct packed {
    logic idleFill;   // receiver idle on this tick: preset frame buffer to ones
    logic shiftIn;    // mid-bit on this tick: shift sampled line into buffer MSB
    logic loadByte;   // stop-bit midpoint: copy data field to output
    logic endFrame;   // 3/4 of stop bit: evaluate framing, maybe invert flag
  } rxStrobes_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clear,
  input  logic lineIn,
  output logic lineSync
);

  logic [STAGES-1:0] stageQ;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (clear) stageQ[0] <= 1'b1;
          else       stageQ[0] <= lineIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (clear) stageQ[s] <= 1'b1;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign lineSync = stageQ[STAGES-1];

endmodule

// File: rtl/rx_control.sv
module rx_control
  import uart_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter int POS_W      = 8
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             tick16,
  input  logic             lineSync,
  output logic [POS_W-1:0] position,
  output rxStrobes_t       strobes
);

  localparam int OS_BITS   = $clog2(OVERSAMPLE);
  localparam int MID_OFF   = OVERSAMPLE / 2 - 1;
  localparam int END_OFF   = (OVERSAMPLE * 3) / 4;
  localparam int STOP_IDX  = DATA_W + 1;

  localparam logic [POS_W-1:0]   POS_IDLE  = '0;
  localparam logic [POS_W-1:0]   POS_FIRST = POS_W'(1);
  localparam logic [POS_W-1:0]   POS_START = POS_W'(MID_OFF);
  localparam logic [POS_W-1:0]   POS_STOP  = POS_W'(STOP_IDX * OVERSAMPLE + MID_OFF);
  localparam logic [POS_W-1:0]   POS_END   = POS_W'(STOP_IDX * OVERSAMPLE + END_OFF);
  localparam logic [OS_BITS-1:0] PHASE_MID = OS_BITS'(MID_OFF);

  logic isIdle;
  logic atMid;
  logic startFalse;
  logic atEnd;

  assign isIdle     = (position == POS_IDLE);
  assign atMid      = !isIdle && (position[OS_BITS-1:0] == PHASE_MID);
  assign startFalse = (position == POS_START) && lineSync;
  assign atEnd      = (position == POS_END);

  always_ff @(posedge clk) begin
    if (clear) begin
      position <= POS_IDLE;
    end else if (tick16) begin
      if (isIdle) begin
        if (!lineSync) position <= POS_FIRST;
      end else if (startFalse || atEnd) begin
        position <= POS_IDLE;
      end else begin
        position <= position + POS_FIRST;
      end
    end
  end

  always_comb begin
    strobes.idleFill = tick16 && isIdle;
    strobes.shiftIn  = tick16 && atMid;
    strobes.loadByte = tick16 && (position == POS_STOP);
    strobes.endFrame = tick16 && atEnd;
  end

endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              lineSync,
  input  rxStrobes_t        strobes,
  output logic [DATA_W-1:0] rxByte,
  output logic              byteToggle
);

  localparam int FRAME_W = DATA_W + 2;

  logic [FRAME_W-1:0] frameBuf;
  logic               framingOk;

  // Oldest sample (start) settles in bit 0, newest (stop) in the MSB.
  assign framingOk = frameBuf[FRAME_W-1] && !frameBuf[0];

  always_ff @(posedge clk) begin
    if (clear) begin
      frameBuf <= '1;
    end else if (strobes.idleFill) begin
      frameBuf <= '1;
    end else if (strobes.shiftIn) begin
      frameBuf <= {lineSync, frameBuf[FRAME_W-1:1]};
    end
  end

  // At the stop midpoint the buffer still holds start + data; data sits on top.
  always_ff @(posedge clk) begin
    if (clear)                 rxByte <= '0;
    else if (strobes.loadByte) rxByte <= frameBuf[FRAME_W-1 -: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (clear)                              byteToggle <= 1'b0;
    else if (strobes.endFrame && framingOk) byteToggle <= !byteToggle;
  end

endmodule

// File: rtl/uart_oversample_rx.sv
module uart_oversample_rx
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              tick16,
  input  logic              serialIn,
  output logic [DATA_W-1:0] rxByte,
  output logic              byteToggle
);

  localparam int POS_W = $clog2((DATA_W + 2) * OVERSAMPLE);

  logic             lineSync;
  logic [POS_W-1:0] position;
  rxStrobes_t       strobes;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .clear    (clear),
    .lineIn   (serialIn),
    .lineSync (lineSync)
  );

  rx_control #(
    .DATA_W     (DATA_W),
    .OVERSAMPLE (OVERSAMPLE),
    .POS_W      (POS_W)
  ) u_ctrl (
    .clk      (clk),
    .clear    (clear),
    .tick16   (tick16),
    .lineSync (lineSync),
    .position (position),
    .strobes  (strobes)
  );

  rx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .clear      (clear),
    .lineSync   (lineSync),
    .strobes    (strobes),
    .rxByte     (rxByte),
    .byteToggle (byteToggle)
  );

endmodule

// File: rtl/uart_oversample_rx_chk.sv
module uart_oversample_rx_chk #(
  parameter int DATA_W = 8,
  parameter int POS_W  = 8,
  parameter int POS_END = 156
) (
  input logic              clk,
  input logic              clear,
  input logic              tick16,
  input logic [DATA_W-1:0] rxByte,
  input logic              byteToggle,
  input logic [POS_W-1:0]  position
);

  // R1: clear leaves zero outputs behind
  a_r1_clear_zero: assert property (@(posedge clk)
    clear |=> (rxByte == '0) && (byteToggle == 1'b0));

  // R1: clear returns the receiver to idle
  a_r1_clear_idle: assert property (@(posedge clk)
    clear |=> (position == '0));

  // R2: a character always begins at position one
  a_r2_start_from_one: assert property (@(posedge clk) disable iff (clear)
    ($past(position) == '0) && (position != '0) |-> (position == POS_W'(1)));

  // R2: position never runs past the end point
  a_r2_position_bound: assert property (@(posedge clk) disable iff (clear)
    position <= POS_W'(POS_END));

  // R3: byte load and flag inversion fall in different cycles
  a_r3_load_toggle_apart: assert property (@(posedge clk) disable iff (clear)
    !$stable(byteToggle) |-> $stable(rxByte));

  // R6: outputs move only after an enable tick
  a_r6_byte_needs_tick: assert property (@(posedge clk) disable iff (clear)
    !$stable(rxByte) |-> $past(tick16));

  a_r6_toggle_needs_tick: assert property (@(posedge clk) disable iff (clear)
    !$stable(byteToggle) |-> $past(tick16));

  a_r6_position_needs_tick: assert property (@(posedge clk) disable iff (clear)
    !$stable(position) |-> $past(tick16));

endmodule

bind uart_oversample_rx uart_oversample_rx_chk #(
  .DATA_W  (DATA_W),
  .POS_W   (POS_W),
  .POS_END ((DATA_W + 1) * OVERSAMPLE + (OVERSAMPLE * 3) / 4)
) u_chk (
  .clk        (clk),
  .clear      (clear),
  .tick16     (tick16),
  .rxByte     (rxByte),
  .byteToggle (byteToggle),
  .position   (position)
);

// File: tb/uart_oversample_rx_tb.sv
module uart_oversample_rx_tb;

  localparam int NOM = 32;  // clocks per bit: tick16 every 2 clocks

  logic       clk = 1'b0;
  logic       clear = 1'b1;
  logic       tick16 = 1'b0;
  logic       tickOn = 1'b0;
  logic       serialIn = 1'b1;
  logic [7:0] rxByte;
  logic       byteToggle;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] expByte = 8'h00;
  logic       expTog = 1'b0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (tickOn) tick16 <= ~tick16;
    else        tick16 <= 1'b0;
  end

  uart_oversample_rx u_dut (
    .clk        (clk),
    .clear      (clear),
    .tick16     (tick16),
    .serialIn   (serialIn),
    .rxByte     (rxByte),
    .byteToggle (byteToggle)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic holdLine(input logic v, input int clks);
    serialIn = v;
    repeat (clks) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] b, input int bitClks, input logic stopV);
    holdLine(1'b0, bitClks);
    for (int i = 0; i < 8; i++) holdLine(b[i], bitClks);
    holdLine(stopV, bitClks);
    serialIn = 1'b1;
  endtask

  task automatic checkOut(input string req);
    check(req, {1'b0, rxByte}, {1'b0, expByte});
    check(req, {8'h00, byteToggle}, {8'h00, expTog});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog actual=%0d expected=%0d", testsRun, -1);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: state after clear
    checkOut("R1 reset");
    clear = 1'b0;
    tickOn = 1'b1;
    repeat (40) @(negedge clk);
    checkOut("R1 idle after clear");

    // R2, R3: sweep every byte value at the nominal rate
    for (int b = 0; b < 256; b++) begin
      sendFrame(8'(b), NOM, 1'b1);
      expByte = 8'(b);
      expTog  = ~expTog;
      holdLine(1'b1, 8);
      checkOut("R2 R3 sweep");
    end

    // R4: glitch of three ticks, shorter than half a bit
    holdLine(1'b0, 6);
    holdLine(1'b1, 12 * NOM);
    checkOut("R4 glitch");
    holdLine(1'b0, 12);
    holdLine(1'b1, 12 * NOM);
    checkOut("R4 glitch near midpoint");

    // R5: low stop bit loads data but leaves flag alone
    sendFrame(8'h5A, NOM, 1'b0);
    holdLine(1'b1, 12 * NOM);
    expByte = 8'h5A;
    checkOut("R5 bad stop");

    // R6: no ticks, no effect
    tickOn = 1'b0;
    repeat (4) @(negedge clk);
    sendFrame(8'hC3, NOM, 1'b1);
    holdLine(1'b1, 40);
    checkOut("R6 no tick");
    tickOn = 1'b1;
    holdLine(1'b1, 2 * NOM);
    checkOut("R6 resume idle");

    // R7: back-to-back nominal, checked at each frame end
    for (int k = 0; k < 4; k++) begin
      sendFrame(8'h11 * 8'(k + 3), NOM, 1'b1);
      expByte = 8'h11 * 8'(k + 3);
      expTog  = ~expTog;
      checkOut("R7 back to back");
    end
    holdLine(1'b1, NOM);

    // R8: slow sender back to back
    for (int k = 0; k < 4; k++) begin
      sendFrame(8'hA5 ^ 8'(k * 37), NOM + 1, 1'b1);
      expByte = 8'hA5 ^ 8'(k * 37);
      expTog  = ~expTog;
      checkOut("R8 slow sender");
    end
    holdLine(1'b1, NOM);

    // R8: fast sender with one idle bit between characters
    for (int k = 0; k < 4; k++) begin
      sendFrame(8'h3C + 8'(k * 71), NOM - 1, 1'b1);
      holdLine(1'b1, NOM - 1);
      expByte = 8'h3C + 8'(k * 71);
      expTog  = ~expTog;
      checkOut("R8 fast sender");
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule